// File: doc/BRIEF.md
# Timed I/Q Stream Command Sequencer

This block takes a single ingress stream of tagged words through a valid/ready handshake and plays it out toward a DAC at a fixed sample cadence. Most words are I/Q sample pairs. The rest are in-band control commands. A command can load a new LO frequency word, set a new amplitude (gain) state, or arm a trigger pulse. Every command takes effect at its exact place in the stream. After an LO or amplitude command, the block zeroes the sample output and stops accepting words for a fixed settle time, counted in clock cycles, so that the analog hardware can settle. An armed trigger fires on the same clock edge that presents the next sample, which keeps the trigger aligned with the RF output. Triggers are spaced by a minimum interval.

A free-running cadence counter produces a slot tick once every `SAMPLE_DIV` cycles. Sample words are accepted only on tick cycles. Command words are accepted only on the cycles between ticks. `SAMPLE_DIV` must therefore be at least 2.

The sequencer state machine has three states:

- `ST_WAIT`: no stream is active. This is the state after reset and after every settle interval.
- `ST_RUN`: samples are streaming.
- `ST_SETTLE`: a settle interval is in progress.

Its transitions are:

- `ST_WAIT` to `ST_RUN` when a sample is accepted.
- `ST_WAIT` or `ST_RUN` to `ST_SETTLE` when an LO or amplitude command is accepted.
- `ST_SETTLE` to `ST_WAIT` when the settle counter reaches zero.

Every other case holds the current state.

Top module: `iqcmd_sequencer`

## Requirements
- R1: After reset:
  - `iq_i`, `iq_q`, `lo_freq` and `gain_state` are zero.
  - `iq_stb`, `lo_stb`, `trig_out` and `underrun` are low.
  - The state is `ST_WAIT`.
- R2: A word whose top two bits are 00 is a sample. Payload bits [2*SAMP_W-1:SAMP_W] are I and bits [SAMP_W-1:0] are Q. A sample is accepted only on a tick cycle, so accepted samples are `SAMPLE_DIV` cycles apart. The sample appears on `iq_i`/`iq_q` at the accepting edge, with `iq_stb` high for that one cycle.
- R3: Command words (tags 01, 10, 11) are accepted only on non-tick cycles. Every word is consumed in stream order.
- R4: Tag 01 loads `lo_freq` from payload bits [LO_W-1:0] and pulses `lo_stb` for one cycle. The block then enters `ST_SETTLE` for `LO_SETTLE` cycles. The next sample is therefore accepted between `LO_SETTLE`+1 and `LO_SETTLE`+`SAMPLE_DIV` cycles after the command.
- R5: Tag 10 loads `gain_state` from payload bits [GAIN_W-1:0]. The block then settles for `AMP_SETTLE` cycles, with the same acceptance window as R4.
- R6: Tag 11 arms a trigger with width payload bits [TW_W-1:0]. `trig_out` rises on the edge that presents the next accepted sample, stays high for that many cycles, and a width of 0 gives 1 cycle.
- R7:
  - Rising edges of `trig_out` are at least `TRIG_GAP` cycles apart. A trigger armed earlier than that is delayed to the first sample after the spacing has elapsed.
  - While a trigger is armed, a further trigger word is not accepted.
- R8: In `ST_RUN`, a tick with no accepted sample drives a zero sample with `iq_stb` high and sets `underrun`. `underrun` stays set until reset.
- R9: In `ST_WAIT`, a tick with no sample does not set `underrun`.
- R10: Throughout `ST_SETTLE`, `iq_i` and `iq_q` are zero and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress word valid |
| in_word | input | 2*SAMP_W+2 | Tag in the top two bits, payload below |
| in_ready | output | 1 | Ingress word accepted when high with in_valid |
| iq_i | output | SAMP_W | In-phase sample to the DAC |
| iq_q | output | SAMP_W | Quadrature sample to the DAC |
| iq_stb | output | 1 | One-cycle strobe for each sample slot update |
| lo_freq | output | LO_W | LO frequency word |
| lo_stb | output | 1 | One-cycle LO program strobe |
| gain_state | output | GAIN_W | Amplitude state |
| trig_out | output | 1 | Trigger pulse aligned with a sample |
| underrun | output | 1 | Sticky stream underflow flag |

## Verification
The bench builds the block with the following parameters:

- `SAMPLE_DIV`=4
- `SAMP_W`=8
- `LO_W`=16
- `LO_SETTLE`=24
- `AMP_SETTLE`=10
- `TRIG_GAP`=40

With these values, a settle interval, a delayed second trigger and the spacing limit all fit in a few dozen cycles. The measured gaps can then be compared with exact cycle windows. Because the cadence is 4, command acceptance between ticks is visible, and so is a command word stalling a tick.

// File: rtl/iqs_pkg.sv
package iqs_pkg;
    typedef enum logic [1:0] {
        TAG_IQ   = 2'b00,
        TAG_LO   = 2'b01,
        TAG_AMP  = 2'b10,
        TAG_TRIG = 2'b11
    } word_tag_e;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/iqs_cadence.sv
module iqs_cadence #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    initial begin
        assert (DIV >= 2) else $error("sample cadence must be at least 2 cycles");
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (cnt == CW'(DIV-1))  cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(DIV-1));

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: rtl/iqs_trigger.sv
module iqs_trigger #(
    parameter int TRIG_GAP = 100000,
    parameter int TW_W     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [TW_W-1:0] req_width,
    input  logic            emit,
    output logic            pend,
    output logic            trig
);
    localparam int GW = $clog2(TRIG_GAP + 1);

    logic [TW_W-1:0] width_q;
    logic [TW_W-1:0] hold;
    logic [GW-1:0]   gap;
    logic            fire;

    assign fire = pend && (gap == '0) && emit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            width_q <= '0;
            hold    <= '0;
            gap     <= '0;
            trig    <= 1'b0;
        end else begin
            if (req) begin
                pend    <= 1'b1;
                width_q <= req_width;
            end else if (fire) begin
                pend    <= 1'b0;
            end
            if (fire) begin
                trig <= 1'b1;
                hold <= (width_q == '0) ? '0 : width_q - 1'b1;
                gap  <= GW'(TRIG_GAP - 1);
            end else begin
                if (gap != '0) gap <= gap - 1'b1;
                if (trig) begin
                    if (hold == '0) trig <= 1'b0;
                    else            hold <= hold - 1'b1;
                end
            end
        end
    end

    AST_TRIG_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(pend)); // R6
endmodule

// File: rtl/iqcmd_sequencer.sv
module iqcmd_sequencer
    import iqs_pkg::*;
#(
    parameter int SAMP_W     = 12,
    parameter int LO_W       = 24,
    parameter int GAIN_W     = 4,
    parameter int TW_W       = 8,
    parameter int SAMPLE_DIV = 2,
    parameter int LO_SETTLE  = 20000,
    parameter int AMP_SETTLE = 1000,
    parameter int TRIG_GAP   = 100000,
    localparam int WORD_W    = 2*SAMP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic [SAMP_W-1:0] iq_i,
    output logic [SAMP_W-1:0] iq_q,
    output logic              iq_stb,
    output logic [LO_W-1:0]   lo_freq,
    output logic              lo_stb,
    output logic [GAIN_W-1:0] gain_state,
    output logic              trig_out,
    output logic              underrun
);
    localparam int PAY_W   = 2*SAMP_W;
    localparam int SET_MAX = (LO_SETTLE > AMP_SETTLE) ? LO_SETTLE : AMP_SETTLE;
    localparam int SCW     = $clog2(SET_MAX + 1);
    localparam int GCW     = $clog2(TRIG_GAP + 1) + 1;

    seq_state_e       state, state_nx;
    logic [SCW-1:0]   settle_cnt;
    word_tag_e        tag;
    logic [PAY_W-1:0] pay;
    logic             tick, trig_pend;
    logic             take_iq, take_lo, take_amp, take_trig;

    assign tag = word_tag_e'(in_word[WORD_W-1 -: 2]);
    assign pay = in_word[PAY_W-1:0];

    iqs_cadence #(.DIV(SAMPLE_DIV)) u_cad (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    always_comb begin
        in_ready = 1'b0;
        if (state != ST_SETTLE) begin
            if (tick)                in_ready = (tag == TAG_IQ);
            else if (tag == TAG_TRIG) in_ready = !trig_pend;
            else                     in_ready = (tag != TAG_IQ);
        end
    end

    assign take_iq   = in_valid && in_ready && (tag == TAG_IQ);
    assign take_lo   = in_valid && in_ready && (tag == TAG_LO);
    assign take_amp  = in_valid && in_ready && (tag == TAG_AMP);
    assign take_trig = in_valid && in_ready && (tag == TAG_TRIG);

    iqs_trigger #(.TRIG_GAP(TRIG_GAP), .TW_W(TW_W)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (take_trig),
        .req_width (pay[TW_W-1:0]),
        .emit      (take_iq),
        .pend      (trig_pend),
        .trig      (trig_out)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT, ST_RUN: begin
                if (take_lo || take_amp) state_nx = ST_SETTLE;
                else if (take_iq)        state_nx = ST_RUN;
            end
            ST_SETTLE: if (settle_cnt == '0) state_nx = ST_WAIT;
            default:   state_nx = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_WAIT;
            settle_cnt <= '0;
        end else begin
            state <= state_nx;
            if (take_lo)                                    settle_cnt <= SCW'(LO_SETTLE - 1);
            else if (take_amp)                              settle_cnt <= SCW'(AMP_SETTLE - 1);
            else if (state == ST_SETTLE && settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iq_i       <= '0;
            iq_q       <= '0;
            iq_stb     <= 1'b0;
            lo_freq    <= '0;
            lo_stb     <= 1'b0;
            gain_state <= '0;
            underrun   <= 1'b0;
        end else begin
            iq_stb <= 1'b0;
            lo_stb <= 1'b0;
            if (take_iq) begin
                iq_i   <= pay[PAY_W-1:SAMP_W];
                iq_q   <= pay[SAMP_W-1:0];
                iq_stb <= 1'b1;
            end else if (take_lo || take_amp) begin
                iq_i <= '0;
                iq_q <= '0;
            end else if (tick && state == ST_RUN) begin
                iq_i     <= '0;
                iq_q     <= '0;
                iq_stb   <= 1'b1;
                underrun <= 1'b1;
            end
            if (take_lo) begin
                lo_freq <= pay[LO_W-1:0];
                lo_stb  <= 1'b1;
            end
            if (take_amp) gain_state <= pay[GAIN_W-1:0];
        end
    end

    logic           trig_d;
    logic [GCW-1:0] since_trig;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_d     <= 1'b0;
            since_trig <= GCW'(TRIG_GAP);
        end else begin
            trig_d <= trig_out;
            if (trig_out && !trig_d)           since_trig <= GCW'(1);
            else if (since_trig < GCW'(TRIG_GAP)) since_trig <= since_trig + 1'b1;
        end
    end

    AST_LO_STB_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_stb |-> (state == ST_SETTLE)); // R4
    AST_LO_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_stb |=> !lo_stb); // R4
    AST_SETTLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> (iq_i == '0 && iq_q == '0 && !iq_stb)); // R10
    AST_STB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        iq_stb |-> $past(tick)); // R2
    AST_TRIG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> iq_stb); // R6
    AST_TRIG_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && !trig_d) |-> (since_trig >= GCW'(TRIG_GAP))); // R7
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R8
endmodule

// File: tb/sim_iqcmd_sequencer.sv
module sim_iqcmd_sequencer;
    localparam int SD = 4, SW = 8, LW = 16, GW = 4, TWW = 8;
    localparam int LS = 24, AS = 10, TG = 40;
    localparam int WW = 2*SW + 2;

    // stimulus payload, expected I, expected Q
    localparam logic [31:0] TV [6] = '{
        {16'h0000, 8'h00, 8'h00}, {16'h7F80, 8'h7F, 8'h80},
        {16'hFF01, 8'hFF, 8'h01}, {16'h55AA, 8'h55, 8'hAA},
        {16'h8000, 8'h80, 8'h00}, {16'h00FF, 8'h00, 8'hFF}};

    logic clk = 0, rst_n = 0, in_valid = 0;
    logic [WW-1:0] in_word = '0;
    logic in_ready, iq_stb, lo_stb, trig_out, underrun;
    logic [SW-1:0] iq_i, iq_q;
    logic [LW-1:0] lo_freq;
    logic [GW-1:0] gain_state;

    int checks = 0, errors = 0, cyc = 0;
    int acc_cyc = 0, acc_prev = 0, wait_nz = 0;
    int rise_cnt = 0, last_rise = 0, prev_rise = 0, hi_len = 0, last_w = 0;
    logic prev_t = 0;

    iqcmd_sequencer #(.SAMP_W(SW), .LO_W(LW), .GAIN_W(GW), .TW_W(TWW),
        .SAMPLE_DIV(SD), .LO_SETTLE(LS), .AMP_SETTLE(AS), .TRIG_GAP(TG)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .iq_i(iq_i), .iq_q(iq_q), .iq_stb(iq_stb),
        .lo_freq(lo_freq), .lo_stb(lo_stb), .gain_state(gain_state),
        .trig_out(trig_out), .underrun(underrun));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (trig_out) begin
            if (!prev_t) begin
                rise_cnt = rise_cnt + 1; prev_rise = last_rise; last_rise = cyc; hi_len = 1;
            end else hi_len = hi_len + 1;
        end else if (prev_t) last_w = hi_len;
        prev_t = trig_out;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] tg, input logic [15:0] pay);
        in_word = {tg, pay}; in_valid = 1; wait_nz = 0;
        #1;
        while (!in_ready) begin
            if (iq_i != 0 || iq_q != 0) wait_nz++;
            @(negedge clk); #1;
        end
        @(negedge clk);
        in_valid = 0; acc_prev = acc_cyc; acc_cyc = cyc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        #1;
        chk(iq_i == 0 && iq_q == 0 && !iq_stb, "R1 iq", int'(iq_i), 0);
        chk(!lo_stb && lo_freq == 0 && gain_state == 0, "R1 lo/gain", int'(lo_freq), 0);
        chk(!trig_out && !underrun, "R1 trig/underrun", int'(underrun), 0);
        repeat (20) @(negedge clk);
        chk(!underrun && iq_i == 0, "R9 idle wait", int'(underrun), 0);

        for (int k = 0; k < 6; k++) begin
            send(2'b00, TV[k][31:16]);
            chk(iq_i == TV[k][15:8] && iq_q == TV[k][7:0], "R2 sample value",
                int'({iq_i, iq_q}), int'(TV[k][15:0]));
            chk(iq_stb == 1'b1, "R2 strobe", int'(iq_stb), 1);
            if (k > 0) chk(acc_cyc - acc_prev == SD, "R2 cadence", acc_cyc - acc_prev, SD);
        end

        send(2'b11, 16'h0003);
        chk(acc_cyc - acc_prev == 1, "R3 command off tick", acc_cyc - acc_prev, 1);
        chk(!trig_out, "R6 trigger waits for sample", int'(trig_out), 0);
        send(2'b00, 16'h1122);
        chk(trig_out && iq_stb, "R6 trigger aligned with sample", int'(trig_out), 1);
        for (int k = 0; k < 4; k++) send(2'b00, 16'h1020);
        chk(last_w == 3, "R6 trigger width", last_w, 3);

        send(2'b11, 16'h0000);
        for (int k = 0; k < 20 && rise_cnt < 2; k++) send(2'b00, 16'h0102);
        chk(rise_cnt == 2, "R7 delayed trigger fired", rise_cnt, 2);
        chk(last_rise - prev_rise >= TG && last_rise - prev_rise < TG + SD,
            "R7 trigger spacing", last_rise - prev_rise, TG);
        send(2'b00, 16'h0102);
        send(2'b00, 16'h0102);
        chk(last_w == 1, "R6 zero width gives one cycle", last_w, 1);

        send(2'b01, 16'hBEEF);
        chk(lo_stb && lo_freq == 16'hBEEF, "R4 lo strobe/word", int'(lo_freq), 16'hBEEF);
        chk(iq_i == 0 && iq_q == 0, "R10 zero at settle", int'({iq_i, iq_q}), 0);
        @(negedge clk);
        chk(!lo_stb, "R4 single strobe", int'(lo_stb), 0);
        chk(!in_ready, "R10 ready low in settle", int'(in_ready), 0);
        begin
            int c0;
            c0 = acc_cyc - 1;
            send(2'b00, 16'h2233);
            chk(acc_cyc - c0 >= LS + 1 && acc_cyc - c0 <= LS + SD, "R4 settle length",
                acc_cyc - c0, LS + 1);
            chk(wait_nz == 0, "R10 iq zero while settling", wait_nz, 0);
            send(2'b10, 16'h0009);
            chk(gain_state == 4'd9, "R5 gain state", int'(gain_state), 9);
            c0 = acc_cyc;
            send(2'b00, 16'h4455);
            chk(acc_cyc - c0 >= AS + 1 && acc_cyc - c0 <= AS + SD, "R5 settle length",
                acc_cyc - c0, AS + 1);
            chk(wait_nz == 0, "R10 iq zero after amp", wait_nz, 0);
        end
        chk(!underrun, "R9 no underrun across settle", int'(underrun), 0);

        send(2'b00, 16'h3344);
        repeat (3*SD) @(negedge clk);
        chk(iq_i == 0 && iq_q == 0, "R8 zero on underflow", int'({iq_i, iq_q}), 0);
        chk(underrun, "R8 underrun set", int'(underrun), 1);
        send(2'b00, 16'h6677);
        chk(underrun && iq_i == 8'h66, "R8 underrun sticky", int'(underrun), 1);

        send(2'b11, 16'h0002);
        in_word = {2'b11, 16'h0005}; in_valid = 1;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk); #1;
                if (in_ready) seen++;
            end
            chk(seen == 0, "R7 second trigger stalled", seen, 0);
        end
        in_valid = 0;
        @(negedge clk);
        send(2'b00, 16'h7788);
        chk(trig_out && iq_stb, "R7 armed trigger fires on sample", int'(trig_out), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule